// File: doc/BRIEF.md
# Batched Descriptor Slot Buffer

This block sits between a host-side producer and a set of downstream packet builders. The producer sends bursts over a 32-bit word stream. Each burst starts with a count word and then carries that many packet descriptors. Each descriptor holds the frame length, the departure time, header words and an optional payload prefix word. The block writes each burst into one of a fixed pool of storage slots. It releases the descriptors downstream one at a time, in arrival order, through a valid/ready handshake.

When every slot holds a burst, the block lowers its input ready, so no stored data is overwritten. A slot returns to the pool only when its last descriptor has been taken. The block keeps a wrapping 32-bit tally of descriptors handed downstream. It sends this tally upstream as a one-cycle credit message, so the producer can compute by modular subtraction how many packets are still outstanding and throttle itself. A message is sent when a batch of unreported completions has built up, or when the block falls idle with completions still unreported.

Top module: `desc_slot_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, `dsc_valid` is 0 and `cr_valid` is 0.
- R2: The low 8 bits of the first word of a burst give its descriptor count. The next words are the descriptors, five words each: word 0 holds the length in bits 10:0 and the prefix-present flag in bit 31; word 1 is the departure time; words 2 and 3 are header words 0 and 1, with header word k at `dsc_hdr` bits 32k+31:32k; word 4 is the prefix. Each descriptor appears on the output fields unchanged.
- R3: While all NUM_SLOTS (10) slots hold bursts, `in_ready` is 0 between bursts and no slot is overwritten. `in_ready` returns to 1 in the cycle after a slot is freed.
- R4: Once a count word has been accepted, `in_ready` stays 1 for every remaining word of that burst.
- R5: Descriptors leave in arrival order, one per `dsc_valid && dsc_ready` cycle. While `dsc_ready` is 0 the presented descriptor is held stable.
- R6: A slot stays occupied until its last descriptor has been accepted downstream.
- R7: A burst whose count is 0 is one word long, occupies no slot and produces no descriptor.
- R8: A count above MAX_DESC (8) is clamped to MAX_DESC. The burst ends after MAX_DESC descriptors, and the next word is a count word.
- R9: When the unreported completions reach CREDIT_BATCH (4), the next cycle carries `cr_valid` with `cr_count` equal to the cumulative completion tally.
- R10: When no slot is occupied, no burst is in progress and completions are unreported, a credit message carrying the full tally follows.
- R11: The completion tally is 32 bits wide and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Burst word |
| in_ready | output | 1 | Input accepts a word (back-pressure when 0) |
| dsc_valid | output | 1 | A descriptor is presented |
| dsc_ready | input | 1 | Downstream takes the descriptor |
| dsc_len | output | 11 | Frame length in bytes |
| dsc_time | output | 32 | Departure time |
| dsc_hdr | output | 64 | Header words, word k at bits 32k+31:32k |
| dsc_pfx_vld | output | 1 | Payload prefix present |
| dsc_pfx | output | 32 | Payload prefix word |
| cr_valid | output | 1 | One-cycle credit message strobe |
| cr_count | output | 32 | Cumulative completed-packet tally |

## Verification
The bench fills every slot and then offers no further burst. A design that let a burst in at that point would overwrite a slot and corrupt the order; one that freed a slot early would raise ready after the first descriptor of a two-descriptor burst instead of after the second. A zero-count burst is placed just before the last free slot is used, so a design that wrongly held a slot for it would stall the tenth burst. An over-long count checks that the word after the clamped burst is parsed as a new count word. The credit sequence is compared exactly against back-to-back consumption: a batch message at 7, then an idle flush at 9. An off-by-one threshold or a missed flush shows up as a wrong or missing count.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 32;

  // Number of descriptors a burst really carries, given its count word.
  function automatic int unsigned clamp_count(logic [7:0] raw, int unsigned cap);
    return (int'(raw) > int'(cap)) ? cap : int'(raw);
  endfunction

  // Completions not yet reported, modulo 2^CNT_W.
  function automatic logic [CNT_W-1:0] unreported(logic [CNT_W-1:0] done_cnt,
                                                  logic [CNT_W-1:0] rep_cnt);
    return done_cnt - rep_cnt;
  endfunction
endpackage

// File: rtl/dsb_slot_pool.sv
module dsb_slot_pool #(
  parameter int NUM_SLOTS  = 10,
  parameter int MAX_DESC   = 8,
  parameter int DESC_WORDS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] alloc_slot,
  input  logic [$clog2(MAX_DESC+1)-1:0] alloc_cnt,
  input  logic wr_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_slot,
  input  logic [$clog2(MAX_DESC*DESC_WORDS)-1:0] wr_idx,
  input  logic [dsb_pkg::WORD_W-1:0] wr_data,
  input  logic rel_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] rel_slot,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
  input  logic [$clog2(MAX_DESC)-1:0] rd_desc,
  output logic [NUM_SLOTS-1:0] free_mask,
  output logic [$clog2(MAX_DESC+1)-1:0] rd_cnt,
  output logic [DESC_WORDS*dsb_pkg::WORD_W-1:0] rd_words
);
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SLOT_WORDS = MAX_DESC * DESC_WORDS;
  localparam int WIDX_W     = $clog2(SLOT_WORDS);
  localparam int CNT_FW     = $clog2(MAX_DESC+1);
  localparam int W          = dsb_pkg::WORD_W;

  logic [W-1:0]      mem [NUM_SLOTS][SLOT_WORDS];
  logic [CNT_FW-1:0] slot_cnt [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_mask <= '1;
    end else begin
      if (alloc_en) free_mask[alloc_slot] <= 1'b0;
      if (rel_en)   free_mask[rel_slot]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) slot_cnt[alloc_slot] <= alloc_cnt;
    if (wr_en)    mem[wr_slot][wr_idx] <= wr_data;
  end

  assign rd_cnt = slot_cnt[rd_slot];

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_rd
    logic [WIDX_W-1:0] idx;
    assign idx = WIDX_W'(rd_desc) * WIDX_W'(DESC_WORDS) + WIDX_W'(k);
    assign rd_words[k*W +: W] = mem[rd_slot][idx];
  end

  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_mask[alloc_slot]);
  // R6
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> !free_mask[rel_slot]);

  logic [SLOT_W-1:0] unused_slot_w;
  assign unused_slot_w = '0;
endmodule

// File: rtl/dsb_order_fifo.sv
module dsb_order_fifo #(
  parameter int DEPTH = 10,
  parameter int DW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic [DW-1:0] push_data,
  input  logic pop,
  output logic [DW-1:0] head,
  output logic empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] q [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        q[wp] <= push_data;
        wp    <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign head  = q[rp];
  assign empty = (cnt == '0);

  // R5
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)) || pop);
  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dsb_writer.sv
module dsb_writer #(
  parameter int NUM_SLOTS  = 10,
  parameter int MAX_DESC   = 8,
  parameter int DESC_WORDS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic [dsb_pkg::WORD_W-1:0] in_data,
  output logic in_ready,
  input  logic [NUM_SLOTS-1:0] free_mask,
  output logic alloc_en,
  output logic [$clog2(NUM_SLOTS)-1:0] alloc_slot,
  output logic [$clog2(MAX_DESC+1)-1:0] alloc_cnt,
  output logic wr_en,
  output logic [$clog2(NUM_SLOTS)-1:0] wr_slot,
  output logic [$clog2(MAX_DESC*DESC_WORDS)-1:0] wr_idx,
  output logic push_en,
  output logic wr_busy
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int WIDX_W = $clog2(MAX_DESC*DESC_WORDS);
  localparam int CNT_FW = $clog2(MAX_DESC+1);

  logic [WIDX_W-1:0] last_idx;
  logic take, head_word, last_word;

  function automatic logic [SLOT_W-1:0] lowest_free(logic [NUM_SLOTS-1:0] m);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS-1; i >= 0; i--) if (m[i]) r = SLOT_W'(i);
    return r;
  endfunction

  assign in_ready   = wr_busy || (free_mask != '0);
  assign take       = in_valid && in_ready;
  assign head_word  = take && !wr_busy;
  assign alloc_cnt  = CNT_FW'(dsb_pkg::clamp_count(in_data[7:0], MAX_DESC));
  assign alloc_slot = lowest_free(free_mask);
  assign alloc_en   = head_word && (alloc_cnt != '0);
  assign wr_en      = take && wr_busy;
  assign last_word  = wr_en && (wr_idx == last_idx);
  assign push_en    = last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy  <= 1'b0;
      wr_slot  <= '0;
      wr_idx   <= '0;
      last_idx <= '0;
    end else if (alloc_en) begin
      wr_busy  <= 1'b1;
      wr_slot  <= alloc_slot;
      wr_idx   <= '0;
      last_idx <= WIDX_W'(alloc_cnt) * WIDX_W'(DESC_WORDS) - 1'b1;
    end else if (wr_en) begin
      wr_idx <= wr_idx + 1'b1;
      if (last_word) wr_busy <= 1'b0;
    end
  end

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> wr_idx <= last_idx);
endmodule

// File: rtl/dsb_unpacker.sv
module dsb_unpacker #(
  parameter int NUM_SLOTS  = 10,
  parameter int MAX_DESC   = 8,
  parameter int DESC_WORDS = 5,
  parameter int HDR_WORDS  = 2,
  parameter int LEN_W      = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty,
  input  logic [$clog2(NUM_SLOTS)-1:0] head_slot,
  input  logic [$clog2(MAX_DESC+1)-1:0] rd_cnt,
  input  logic [DESC_WORDS*dsb_pkg::WORD_W-1:0] rd_words,
  output logic [$clog2(MAX_DESC)-1:0] rd_desc,
  output logic pop,
  output logic consume,
  input  logic dsc_ready,
  output logic dsc_valid,
  output logic [LEN_W-1:0] dsc_len,
  output logic [dsb_pkg::WORD_W-1:0] dsc_time,
  output logic [HDR_WORDS*dsb_pkg::WORD_W-1:0] dsc_hdr,
  output logic dsc_pfx_vld,
  output logic [dsb_pkg::WORD_W-1:0] dsc_pfx
);
  localparam int W      = dsb_pkg::WORD_W;
  localparam int DIDX_W = $clog2(MAX_DESC);

  logic last_desc;

  assign dsc_valid   = !fifo_empty;
  assign consume     = dsc_valid && dsc_ready;
  assign last_desc   = ({1'b0, rd_desc} == ($bits(rd_cnt)+1)'(rd_cnt) - 1'b1);
  assign pop         = consume && last_desc;

  assign dsc_len     = rd_words[LEN_W-1:0];
  assign dsc_pfx_vld = rd_words[W-1];
  assign dsc_time    = rd_words[W +: W];
  assign dsc_hdr     = rd_words[2*W +: HDR_WORDS*W];
  assign dsc_pfx     = rd_words[(2+HDR_WORDS)*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_desc <= '0;
    else if (pop) rd_desc <= '0;
    else if (consume) rd_desc <= rd_desc + 1'b1;
  end

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_time) && $stable(dsc_len)
      && $stable(dsc_hdr));

  logic [W-LEN_W-2:0] unused_w0;
  logic [$clog2(NUM_SLOTS)-1:0] unused_hs;
  assign unused_w0 = rd_words[W-2:LEN_W];
  assign unused_hs = head_slot;
  logic [DIDX_W-1:0] unused_d;
  assign unused_d = '0;
endmodule

// File: rtl/dsb_credit.sv
module dsb_credit #(
  parameter int CREDIT_BATCH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic consume,
  input  logic idle,
  output logic cr_valid,
  output logic [dsb_pkg::CNT_W-1:0] cr_count
);
  localparam int CW = dsb_pkg::CNT_W;

  logic [CW-1:0] done_cnt, rep_cnt, pending;
  logic due;

  assign pending = dsb_pkg::unreported(done_cnt, rep_cnt);
  assign due     = (pending >= CW'(CREDIT_BATCH)) || (idle && pending != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_cnt <= '0;
      rep_cnt  <= '0;
      cr_valid <= 1'b0;
      cr_count <= '0;
    end else begin
      if (consume) done_cnt <= done_cnt + 1'b1;
      cr_valid <= due;
      if (due) begin
        cr_count <= done_cnt;
        rep_cnt  <= done_cnt;
      end
    end
  end

  // R9
  pending_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CW'(CREDIT_BATCH));
  // R11
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> dsb_pkg::unreported(done_cnt, cr_count) <= 32'd1);
endmodule

// File: rtl/desc_slot_buffer.sv
module desc_slot_buffer #(
  parameter int NUM_SLOTS    = 10,
  parameter int MAX_DESC     = 8,
  parameter int HDR_WORDS    = 2,
  parameter int LEN_W        = 11,
  parameter int CREDIT_BATCH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        dsc_valid,
  input  logic        dsc_ready,
  output logic [LEN_W-1:0] dsc_len,
  output logic [31:0] dsc_time,
  output logic [HDR_WORDS*32-1:0] dsc_hdr,
  output logic        dsc_pfx_vld,
  output logic [31:0] dsc_pfx,
  output logic        cr_valid,
  output logic [31:0] cr_count
);
  localparam int DESC_WORDS = 3 + HDR_WORDS;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int WIDX_W     = $clog2(MAX_DESC*DESC_WORDS);
  localparam int CNT_FW     = $clog2(MAX_DESC+1);
  localparam int DIDX_W     = $clog2(MAX_DESC);

  logic [NUM_SLOTS-1:0] free_mask;
  logic alloc_en, wr_en, push_en, wr_busy, pop, consume, fifo_empty, idle;
  logic [SLOT_W-1:0] alloc_slot, wr_slot, head_slot;
  logic [CNT_FW-1:0] alloc_cnt, rd_cnt;
  logic [WIDX_W-1:0] wr_idx;
  logic [DIDX_W-1:0] rd_desc;
  logic [DESC_WORDS*32-1:0] rd_words;

  dsb_writer #(.NUM_SLOTS(NUM_SLOTS), .MAX_DESC(MAX_DESC), .DESC_WORDS(DESC_WORDS)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .free_mask(free_mask), .alloc_en(alloc_en), .alloc_slot(alloc_slot),
    .alloc_cnt(alloc_cnt), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .push_en(push_en), .wr_busy(wr_busy));

  dsb_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .MAX_DESC(MAX_DESC), .DESC_WORDS(DESC_WORDS)) u_pool (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_slot(alloc_slot),
    .alloc_cnt(alloc_cnt), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(in_data), .rel_en(pop), .rel_slot(head_slot), .rd_slot(head_slot),
    .rd_desc(rd_desc), .free_mask(free_mask), .rd_cnt(rd_cnt), .rd_words(rd_words));

  dsb_order_fifo #(.DEPTH(NUM_SLOTS), .DW(SLOT_W)) u_ord (
    .clk(clk), .rst_n(rst_n), .push(push_en), .push_data(wr_slot), .pop(pop),
    .head(head_slot), .empty(fifo_empty));

  dsb_unpacker #(.NUM_SLOTS(NUM_SLOTS), .MAX_DESC(MAX_DESC), .DESC_WORDS(DESC_WORDS),
                 .HDR_WORDS(HDR_WORDS), .LEN_W(LEN_W)) u_unp (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .head_slot(head_slot),
    .rd_cnt(rd_cnt), .rd_words(rd_words), .rd_desc(rd_desc), .pop(pop),
    .consume(consume), .dsc_ready(dsc_ready), .dsc_valid(dsc_valid), .dsc_len(dsc_len),
    .dsc_time(dsc_time), .dsc_hdr(dsc_hdr), .dsc_pfx_vld(dsc_pfx_vld), .dsc_pfx(dsc_pfx));

  assign idle = (&free_mask) && !wr_busy;

  dsb_credit #(.CREDIT_BATCH(CREDIT_BATCH)) u_cr (
    .clk(clk), .rst_n(rst_n), .consume(consume), .idle(idle),
    .cr_valid(cr_valid), .cr_count(cr_count));

  // R6
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !dsc_valid);
endmodule

// File: tb/desc_slot_buffer_tb.sv
module desc_slot_buffer_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, dsc_ready = 0;
  logic [31:0] in_data = 0;
  logic in_ready, dsc_valid, dsc_pfx_vld, cr_valid;
  logic [10:0] dsc_len;
  logic [31:0] dsc_time, dsc_pfx, cr_count;
  logic [63:0] dsc_hdr;

  int checks = 0, failures = 0;
  int exp_q[$];
  int next_seq = 0;
  int cr_log[$];
  int total_done = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  desc_slot_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_len(dsc_len), .dsc_time(dsc_time),
    .dsc_hdr(dsc_hdr), .dsc_pfx_vld(dsc_pfx_vld), .dsc_pfx(dsc_pfx),
    .cr_valid(cr_valid), .cr_count(cr_count));

  always @(negedge clk) if (rst_n && cr_valid) cr_log.push_back(int'(cr_count));

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dword(int s, int k);
    case (k)
      0: return {s[0], 20'd0, 11'(64 + s*3)};
      1: return 32'(1000 + s*7);
      2: return 32'hA000_0000 + 32'(s);
      3: return 32'h5A5A_0000 ^ 32'(s);
      default: return 32'hC0DE_0000 + 32'(s);
    endcase
  endfunction

  task automatic put_word(logic [31:0] d, bit body);
    @(negedge clk);
    in_valid = 1; in_data = d;
    if (body) begin
      checks++;
      if (!in_ready) begin
        failures++;
        $display("FAIL R4 actual=in_ready 0 expected=1");
      end
    end
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic in_off();
    @(negedge clk); in_valid = 0;
  endtask

  // count field raw, descriptors actually sent n
  task automatic send_burst(int raw, int n);
    put_word(32'(raw), 0);
    for (int d = 0; d < n; d++) begin
      for (int k = 0; k < 5; k++) put_word(dword(next_seq, k), 1);
      exp_q.push_back(next_seq);
      next_seq++;
    end
  endtask

  task automatic consume_one(string req);
    int s;
    @(negedge clk);
    dsc_ready = 1;
    while (!dsc_valid) @(negedge clk);
    s = exp_q.pop_front();
    check(req, {dsc_pfx_vld, dsc_len, dsc_time, dsc_hdr},
          {dword(s,0)[31], dword(s,0)[10:0], dword(s,1), dword(s,3), dword(s,2)});
    check("R2 prefix", dsc_pfx, dword(s,4));
    @(posedge clk);
    total_done++;
  endtask

  task automatic rdy_off();
    @(negedge clk); dsc_ready = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 dsc_valid", dsc_valid, 0);
    check("R1 cr_valid", cr_valid, 0);
  endtask

  task automatic t_basic();
    send_burst(3, 3); in_off();
    for (int i = 0; i < 3; i++) consume_one("R2 fields");
    rdy_off(); settle();
    check("R10 flush count", cr_log.size(), 1);
    check("R10 flush value", cr_log[$], 3);
  endtask

  task automatic t_batch();
    int n0 = cr_log.size();
    send_burst(6, 6); in_off();
    for (int i = 0; i < 6; i++) consume_one("R5 order");
    rdy_off(); settle();
    check("R9 msg count", cr_log.size() - n0, 2);
    check("R9 batch value", cr_log[n0], 7);
    check("R10 idle value", cr_log[n0+1], 9);
  endtask

  task automatic t_hold();
    logic [31:0] t0; logic [10:0] l0;
    send_burst(2, 2); in_off();
    while (!dsc_valid) @(negedge clk);
    t0 = dsc_time; l0 = dsc_len;
    repeat (3) @(negedge clk);
    check("R5 hold valid", dsc_valid, 1);
    check("R5 hold data", {dsc_time, dsc_len}, {t0, l0});
    for (int i = 0; i < 2; i++) consume_one("R5 after hold");
    rdy_off(); settle();
    check("R11 tally", cr_log[$], 11);
  endtask

  task automatic t_full();
    for (int b = 0; b < 9; b++) send_burst(2, 2);
    send_burst(0, 0);
    send_burst(2, 2);
    in_off();
    check("R7 zero burst took no slot (20 descs stored)", exp_q.size(), 20);
    check("R3 full back-pressure", in_ready, 0);
    repeat (4) @(negedge clk);
    check("R3 still stalled", in_ready, 0);
    consume_one("R5 full first");
    rdy_off();
    check("R6 slot held mid-burst", in_ready, 0);
    consume_one("R5 full second");
    rdy_off();
    check("R3 slot freed", in_ready, 1);
    send_burst(2, 2); in_off();
    for (int i = 0; i < 20; i++) consume_one("R5 reuse order");
    rdy_off(); settle();
    check("R7 no extra descriptor", dsc_valid, 0);
    check("R10 final tally", cr_log[$], total_done);
  endtask

  task automatic t_clamp();
    send_burst(12, 8);
    send_burst(1, 1); in_off();
    for (int i = 0; i < 9; i++) consume_one("R8 clamp order");
    rdy_off(); settle();
    check("R8 nothing left", dsc_valid, 0);
    check("R11 tally after clamp", cr_log[$], total_done);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_basic();
    t_batch();
    t_hold();
    t_full();
    t_clamp();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule